// File: doc/BRIEF.md
# Prefetch Queue Shadow Tracker

This block watches a processor from outside and keeps a mirror of its instruction prefetch queue. When the surrounding bus logic signals that a code fetch has completed, the byte on the bus is appended to the mirror. A two-bit queue status code from the processor then tells the tracker what the processor did with its queue: nothing, took the first byte of an opcode, took a following byte, or threw the whole queue away. For each byte taken, the tracker presents that byte with a one-cycle valid strobe and a flag telling whether it starts an opcode. Trace, debug and emulation logic can use this to see the instruction stream as it is executed.

The status code describes the queue operation of the previous cycle. The tracker treats each code as acting on the mirror contents that were in place before the same cycle's fetch byte. Any byte fetched in that cycle is appended afterwards, including after a flush. Occupancy is reported continuously. A sticky error flag records any pop from an empty mirror or push into a full one, and the offending operation leaves the contents untouched.

Top module: `iqt_tracker`

## Requirements
- R1: After reset, occupancy is 0, the error flag is 0 and the byte-valid strobe is 0.
- R2: A fetch strobe with code 00 adds the byte to the mirror; occupancy is one higher after the next clock edge.
- R3: Code 00 with no fetch leaves occupancy unchanged and produces no byte-valid strobe.
- R4: Code 01 removes the oldest byte. After the next edge the byte-valid strobe is 1 for exactly one cycle, the byte output carries that byte and the first-byte flag is 1.
- R5: Code 11 removes the oldest byte in the same way as R4, with the first-byte flag at 0.
- R6: Bytes are delivered in the order they were fetched, for up to 4 stored bytes.
- R7: Code 10 empties the mirror. Occupancy is 0 after the next edge and no byte-valid strobe is produced.
- R8: A fetch in the same cycle as code 10 is applied after the flush. Occupancy becomes 1, and that byte is the next one popped.
- R9: A pop code and a fetch in the same cycle pop from the earlier contents and then append. With the mirror full, the pair is accepted without error and occupancy stays 4.
- R10: A pop code (01 or 11) while the mirror is empty sets the error flag. It produces no byte-valid strobe and leaves occupancy at 0.
- R11: A fetch while the mirror holds 4 bytes and no pop is coded sets the error flag. The byte is dropped, and the next four pops return the original four bytes.
- R12: The error flag stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_valid | input | 1 | Code fetch completed this cycle |
| fetch_byte | input | 8 | Byte fetched from the bus |
| queue_code | input | 2 | Queue status: 00 idle, 01 first opcode byte, 10 flush, 11 following byte |
| byte_valid | output | 1 | One-cycle strobe: a byte was taken from the queue |
| byte_data | output | 8 | Byte taken from the queue |
| byte_first | output | 1 | Taken byte starts an opcode |
| occupancy | output | 3 | Bytes currently held in the mirror |
| error | output | 1 | Sticky underflow or overflow flag |

## Verification
Every result is registered once. A fetch or status code presented before a rising edge shows up in occupancy, the byte outputs and the error flag directly after that edge, with no further delay. The bench drives each input set on a falling edge, waits for one rising edge and samples on the next falling edge. A check that a strobe lasts only one cycle samples one full cycle later with idle inputs. Reset release passes through a two-stage synchronizer, so the bench idles several cycles after reset before the first stimulus.

// File: rtl/iqt_pkg.sv
package iqt_pkg;
  typedef enum logic [1:0] {
    QC_IDLE  = 2'b00,
    QC_FIRST = 2'b01,
    QC_FLUSH = 2'b10,
    QC_NEXT  = 2'b11
  } queue_code_e;
endpackage

// File: rtl/iqt_code_decode.sv
module iqt_code_decode
  import iqt_pkg::*;
(
  input  logic [1:0] code,
  output logic       pop,
  output logic       first,
  output logic       flush
);
  queue_code_e code_e;

  always_comb begin
    code_e = queue_code_e'(code);
    pop    = 1'b0;
    first  = 1'b0;
    flush  = 1'b0;
    unique case (code_e)
      QC_FIRST: begin pop = 1'b1; first = 1'b1; end
      QC_NEXT:  pop   = 1'b1;
      QC_FLUSH: flush = 1'b1;
      default:  ;
    endcase
  end
endmodule

// File: rtl/iqt_shadow_fifo.sv
module iqt_shadow_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] head,
  output logic [CNT_W-1:0] count,
  output logic             pop_ok,
  output logic             push_ok
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, rd_d, wr_q, wr_d, wr_mid;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_mid;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Pop or flush acts on prior contents, push follows.
  always_comb begin
    pop_ok  = pop && !flush && (cnt_q != '0);
    rd_d    = rd_q;
    wr_mid  = wr_q;
    cnt_mid = cnt_q;
    if (flush) begin
      rd_d    = '0;
      wr_mid  = '0;
      cnt_mid = '0;
    end else if (pop_ok) begin
      rd_d    = ptr_inc(rd_q);
      cnt_mid = cnt_q - 1'b1;
    end
    push_ok = push && (cnt_mid < CNT_W'(DEPTH));
    wr_d    = push_ok ? ptr_inc(wr_mid) : wr_mid;
    cnt_d   = push_ok ? cnt_mid + 1'b1 : cnt_mid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_ok && (wr_mid == PTR_W'(g))) mem_q[g] <= din;
    end
  end

  assign head  = mem_q[rd_q];
  assign count = cnt_q;

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !push) |=> (cnt_q == '0));
endmodule

// File: rtl/iqt_tracker.sv
module iqt_tracker #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_valid,
  input  logic [WIDTH-1:0] fetch_byte,
  input  logic [1:0]       queue_code,
  output logic             byte_valid,
  output logic [WIDTH-1:0] byte_data,
  output logic             byte_first,
  output logic [CNT_W-1:0] occupancy,
  output logic             error
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             dec_pop, dec_first, dec_flush;
  logic [WIDTH-1:0] head;
  logic [CNT_W-1:0] count;
  logic             pop_ok, push_ok, bad_op;
  logic             vld_q, vld_d, first_q, err_q, err_d;
  logic [WIDTH-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  iqt_code_decode u_dec (
    .code  (queue_code),
    .pop   (dec_pop),
    .first (dec_first),
    .flush (dec_flush)
  );

  iqt_shadow_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .push    (fetch_valid),
    .pop     (dec_pop),
    .flush   (dec_flush),
    .din     (fetch_byte),
    .head    (head),
    .count   (count),
    .pop_ok  (pop_ok),
    .push_ok (push_ok)
  );

  always_comb begin
    bad_op = (dec_pop && !pop_ok) || (fetch_valid && !push_ok);
    err_d  = err_q || bad_op;
    vld_d  = pop_ok;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk) begin
    if (pop_ok) begin
      data_q  <= head;
      first_q <= dec_first;
    end
  end

  assign byte_valid = vld_q;
  assign byte_data  = data_q;
  assign byte_first = first_q;
  assign occupancy  = count;
  assign error      = err_q;

  a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_int_n)
    error |=> error);
  a_r10_underflow: assert property (@(posedge clk) disable iff (!rst_int_n)
    (queue_code[0] && occupancy == '0) |=> (error && !byte_valid));
  a_r4_pop_strobe: assert property (@(posedge clk) disable iff (!rst_int_n)
    (queue_code[0] && occupancy != '0) |=> byte_valid);
  a_r5_first_flag: assert property (@(posedge clk) disable iff (!rst_int_n)
    (queue_code[0] && occupancy != '0) |=> (byte_first == !$past(queue_code[1])));
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    (queue_code == 2'b00 && !fetch_valid) |=> (!byte_valid && $stable(occupancy)));
endmodule

// File: tb/iqt_tracker_tb_top.sv
module iqt_tracker_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       fetch_valid;
  logic [7:0] fetch_byte;
  logic [1:0] queue_code;
  logic       byte_valid;
  logic [7:0] byte_data;
  logic       byte_first;
  logic [2:0] occupancy;
  logic       error;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  iqt_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_byte(fetch_byte),
    .queue_code(queue_code), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_first(byte_first), .occupancy(occupancy), .error(error)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive at falling edge, one rising edge, sample at next falling edge.
  task automatic step(input bit fv, input logic [7:0] fb, input logic [1:0] qc);
    fetch_valid = fv; fetch_byte = fb; queue_code = qc;
    @(posedge clk);
    @(negedge clk);
    fetch_valid = 1'b0; queue_code = 2'b00;
  endtask

  task automatic do_reset();
    fetch_valid = 1'b0; fetch_byte = 8'h00; queue_code = 2'b00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pop_expect(input logic [1:0] qc, input logic [7:0] exp_b, input string req);
    step(1'b0, 8'h00, qc);
    chk(byte_valid === 1'b1, req, byte_valid, 1);
    chk(byte_data === exp_b, req, byte_data, exp_b);
    chk(byte_first === (qc == 2'b01), req, byte_first, qc == 2'b01);
  endtask

  task automatic t_reset();
    do_reset();
    chk(occupancy === 3'd0, "R1", occupancy, 0);
    chk(error === 1'b0, "R1", error, 0);
    chk(byte_valid === 1'b0, "R1", byte_valid, 0);
  endtask

  task automatic t_push_pop();
    do_reset();
    step(1'b1, 8'hA1, 2'b00);
    chk(occupancy === 3'd1, "R2", occupancy, 1);
    step(1'b1, 8'hB2, 2'b00);
    chk(occupancy === 3'd2, "R2", occupancy, 2);
    step(1'b0, 8'h00, 2'b00);
    chk(occupancy === 3'd2 && byte_valid === 1'b0, "R3", occupancy, 2);
    pop_expect(2'b01, 8'hA1, "R4");
    step(1'b0, 8'h00, 2'b00);
    chk(byte_valid === 1'b0, "R4 one-cycle strobe", byte_valid, 0);
    pop_expect(2'b11, 8'hB2, "R5");
    chk(occupancy === 3'd0 && error === 1'b0, "R5", occupancy, 0);
  endtask

  task automatic t_order();
    do_reset();
    for (int i = 0; i < 4; i++) step(1'b1, 8'h10 + 8'(i), 2'b00);
    chk(occupancy === 3'd4, "R6", occupancy, 4);
    pop_expect(2'b01, 8'h10, "R6");
    pop_expect(2'b11, 8'h11, "R6");
    pop_expect(2'b11, 8'h12, "R6");
    pop_expect(2'b01, 8'h13, "R6");
  endtask

  task automatic t_flush();
    do_reset();
    for (int i = 0; i < 3; i++) step(1'b1, 8'h20 + 8'(i), 2'b00);
    step(1'b0, 8'h00, 2'b10);
    chk(occupancy === 3'd0 && byte_valid === 1'b0, "R7", occupancy, 0);
    for (int i = 0; i < 3; i++) step(1'b1, 8'h30 + 8'(i), 2'b00);
    step(1'b1, 8'h5C, 2'b10);
    chk(occupancy === 3'd1, "R8", occupancy, 1);
    pop_expect(2'b01, 8'h5C, "R8");
    chk(error === 1'b0, "R8", error, 0);
  endtask

  task automatic t_pop_push();
    do_reset();
    step(1'b1, 8'h41, 2'b00);
    step(1'b1, 8'h42, 2'b01);
    chk(byte_valid === 1'b1 && byte_data === 8'h41, "R9", byte_data, 8'h41);
    chk(occupancy === 3'd1, "R9", occupancy, 1);
    for (int i = 0; i < 3; i++) step(1'b1, 8'h43 + 8'(i), 2'b00);
    step(1'b1, 8'h46, 2'b11);
    chk(occupancy === 3'd4 && error === 1'b0, "R9 full", occupancy, 4);
    chk(byte_data === 8'h42 && byte_first === 1'b0, "R9 full", byte_data, 8'h42);
    pop_expect(2'b11, 8'h43, "R9");
    pop_expect(2'b11, 8'h44, "R9");
    pop_expect(2'b11, 8'h45, "R9");
    pop_expect(2'b11, 8'h46, "R9");
  endtask

  task automatic t_underflow();
    do_reset();
    step(1'b0, 8'h00, 2'b11);
    chk(error === 1'b1, "R10", error, 1);
    chk(byte_valid === 1'b0 && occupancy === 3'd0, "R10", occupancy, 0);
    for (int i = 0; i < 5; i++) step(1'b0, 8'h00, 2'b00);
    chk(error === 1'b1, "R12", error, 1);
    step(1'b1, 8'h77, 2'b00);
    pop_expect(2'b01, 8'h77, "R12 still tracks");
    chk(error === 1'b1, "R12", error, 1);
    do_reset();
    chk(error === 1'b0, "R12 reset clears", error, 0);
    step(1'b0, 8'h00, 2'b01);
    chk(error === 1'b1 && byte_valid === 1'b0, "R10 code 01", error, 1);
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 0; i < 4; i++) step(1'b1, 8'h60 + 8'(i), 2'b00);
    chk(error === 1'b0, "R11 pre", error, 0);
    step(1'b1, 8'hEE, 2'b00);
    chk(error === 1'b1 && occupancy === 3'd4, "R11", occupancy, 4);
    for (int i = 0; i < 4; i++) pop_expect(2'b11, 8'h60 + 8'(i), "R11");
    chk(occupancy === 3'd0, "R11", occupancy, 0);
  endtask

  initial begin
    t_reset();
    t_push_pop();
    t_order();
    t_flush();
    t_pop_push();
    t_underflow();
    t_overflow();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule